// File: doc/BRIEF.md
# Flash Status Register Unit

This unit holds the 8-bit status word of a flash-style memory and follows the life cycle of the program/erase engine: idle, busy, suspend requested, and suspended. It takes already decoded command strobes (status read, array read, status clear, suspend, resume), single-cycle event pulses from the engine (start, paused, done and four error categories), and the active-low chip-enable and output-enable strobes of the memory bus.

The status word is built from the engine state and from four sticky error flags. A bus read sees a copy of that word taken when either strobe falls; the copy then stays still until the next falling strobe. Only single reads update the copy; a read flagged as burst leaves it alone. A read-select output tells the data path whether bus reads return array data or the status word. It is forced to status when an operation starts, and it can be returned to array data only while the engine is idle or suspended.

Top module: `flash_status_unit`

## Requirements
- R1: After reset, `rd_data` is 0x80 (only bit 7 set) and `rd_sel_status` is 0 (array data).
- R2: Bit 7 (ready) is 0 while the engine is busy or a suspend is pending, and 1 while it is idle or suspended.
- R3: Bit 6 (suspended) becomes 1 on the engine's paused pulse after a suspend command and returns to 0 on a resume command. If done arrives before paused, bit 6 stays 0 and bit 7 returns to 1.
- R4: Bit 0 (suspend pending) is 1 from a suspend command accepted while busy until paused or done. Bit 2 always reads 0.
- R5: Error flags are sticky: `eng_err[0]`, `[1]`, `[2]` and `[3]` set bits 1, 3, 4 and 5. They stay set until a clear-status command or reset.
- R6: When an error event and a clear-status command arrive in the same cycle, the clear wins and the flag stays 0.
- R7: A start accepted while idle, or a read-status command, selects status reads. A read-array command selects array reads only while the engine is idle or suspended, and it is ignored otherwise.
- R8: A falling edge of `ce_n` or of `oe_n`, sampled on a clock edge, copies the status word into `rd_data` at that edge. With no falling edge, `rd_data` holds its value.
- R9: A falling strobe edge while `burst_rd` is 1 leaves `rd_data` unchanged.
- R10: A suspend command while the engine is idle is ignored: bits 6, 7 and 0 keep their values.
- R11: When busy, done takes priority over suspend. When a suspend is pending, done takes priority over paused. Start is accepted only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| cmd_rd_status | input | 1 | Read-status command strobe |
| cmd_rd_array | input | 1 | Read-array command strobe |
| cmd_clr_status | input | 1 | Clear-status command strobe |
| cmd_suspend | input | 1 | Suspend command strobe |
| cmd_resume | input | 1 | Resume command strobe |
| eng_start | input | 1 | Engine began a program or erase |
| eng_paused | input | 1 | Engine reached its suspend point |
| eng_done | input | 1 | Engine finished its operation |
| eng_err | input | 4 | Error event pulses, one per category |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| burst_rd | input | 1 | Current bus read is a burst read |
| rd_data | output | 8 | Status word copy presented to the bus |
| rd_sel_status | output | 1 | 1: bus reads return status, 0: array data |

## Verification
Commands and engine events change the internal status word at the clock edge that samples them. `rd_sel_status` changes at that same edge. `rd_data` takes a new value only at the edge that first samples a strobe low, so a status change shows up on the port after the following strobe fall. The bench drives inputs on falling clock edges and compares the outputs on the next falling edge against a cycle model that it updates on each rising edge. Its directed reads wait until one full edge has passed after the strobe falls before they compare against the constant expected words.

// File: rtl/fsu_pkg.sv
// Package: shared constants and types of the flash status register unit.
// Assumes an 8-bit status word with fixed bit meanings decoded by software.
package fsu_pkg;
    localparam int STAT_W    = 8;
    localparam int ERR_N     = 4;
    localparam int READY_BIT = 7;
    localparam int SUSP_BIT  = 6;
    localparam int PEND_BIT  = 0;
    // status bit fed by each error category, in eng_err index order
    localparam int ERR_POS [ERR_N] = '{1, 3, 4, 5};
    localparam logic [STAT_W-1:0] STAT_RST = 8'h80;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_BUSY = 2'd1,
        ENG_PEND = 2'd2,
        ENG_SUSP = 2'd3
    } eng_state_t;
endpackage

// File: rtl/fsu_engine_track.sv
// Module: follows the program/erase engine through idle, busy, suspend
// pending and suspended. Assumes event inputs are single-cycle pulses; an
// event that does not fit the current state is ignored.
module fsu_engine_track
    import fsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       paused,
    input  logic       done,
    input  logic       suspend,
    input  logic       resume,
    output eng_state_t state
);
    eng_state_t state_d;

    // next engine state; done outranks suspend and paused
    always_comb begin
        state_d = state;
        unique case (state)
            ENG_IDLE: if (start) state_d = ENG_BUSY;
            ENG_BUSY: begin
                if (done)         state_d = ENG_IDLE;
                else if (suspend) state_d = ENG_PEND;
            end
            ENG_PEND: begin
                if (done)         state_d = ENG_IDLE;
                else if (paused)  state_d = ENG_SUSP;
            end
            ENG_SUSP: if (resume) state_d = ENG_BUSY;
            default:  state_d = ENG_IDLE;
        endcase
    end

    // state register with synchronous reset to idle
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= state_d;
    end
endmodule

// File: rtl/fsu_err_flags.sv
// Module: sticky error flags, one per category. Assumes a clear in the same
// cycle as an event takes priority.
module fsu_err_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] evt,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // one flag: set by its event, dropped by clear or reset
        always_ff @(posedge clk) begin
            if (!rst_n || clr) flags[g] <= 1'b0;
            else if (evt[g])   flags[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/fsu_read_mode.sv
// Module: chooses whether bus reads return status or array data. Assumes the
// engine state is the registered state of the current cycle.
module fsu_read_mode
    import fsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rd_status,
    input  logic       rd_array,
    input  eng_state_t state,
    output logic       sel_status
);
    logic may_leave;

    // array reads may be chosen only while the engine is not running
    always_comb may_leave = (state == ENG_IDLE) || (state == ENG_SUSP);

    // read-select register; an accepted start forces status reads
    always_ff @(posedge clk) begin
        if (!rst_n)                                sel_status <= 1'b0;
        else if (start && state == ENG_IDLE)       sel_status <= 1'b1;
        else if (rd_status)                        sel_status <= 1'b1;
        else if (rd_array && may_leave)            sel_status <= 1'b0;
    end
endmodule

// File: rtl/fsu_snapshot.sv
// Module: copies the status word on a falling chip-enable or output-enable
// edge and holds it. Assumes strobes are already synchronous to clk.
module fsu_snapshot #(
    parameter int                W       = 8,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_n,
    input  logic         oe_n,
    input  logic         burst,
    input  logic [W-1:0] status_in,
    output logic [W-1:0] data
);
    logic ce_q, oe_q, fall;

    // strobe history; follows the pins even in reset so no false edge appears
    always_ff @(posedge clk) begin
        ce_q <= ce_n;
        oe_q <= oe_n;
    end

    // a fall on either strobe starts a read
    always_comb fall = (ce_q && !ce_n) || (oe_q && !oe_n);

    // copy register; burst reads leave it untouched
    always_ff @(posedge clk) begin
        if (!rst_n)               data <= RST_VAL;
        else if (fall && !burst)  data <= status_in;
    end
endmodule

// File: rtl/flash_status_unit.sv
// Module: top of the flash status register unit. Builds the status word from
// engine state and sticky error flags and presents a strobe-timed copy.
// Assumes all inputs are synchronous to clk.
module flash_status_unit
    import fsu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_rd_status,
    input  logic                 cmd_rd_array,
    input  logic                 cmd_clr_status,
    input  logic                 cmd_suspend,
    input  logic                 cmd_resume,
    input  logic                 eng_start,
    input  logic                 eng_paused,
    input  logic                 eng_done,
    input  logic [ERR_N-1:0]     eng_err,
    input  logic                 ce_n,
    input  logic                 oe_n,
    input  logic                 burst_rd,
    output logic [STAT_W-1:0]    rd_data,
    output logic                 rd_sel_status
);
    eng_state_t          eng_state;
    logic [ERR_N-1:0]    err_flags;
    logic [STAT_W-1:0]   status_w;

    fsu_engine_track u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .paused  (eng_paused),
        .done    (eng_done),
        .suspend (cmd_suspend),
        .resume  (cmd_resume),
        .state   (eng_state)
    );

    fsu_err_flags #(.N(ERR_N)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cmd_clr_status),
        .evt   (eng_err),
        .flags (err_flags)
    );

    fsu_read_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (eng_start),
        .rd_status  (cmd_rd_status),
        .rd_array   (cmd_rd_array),
        .state      (eng_state),
        .sel_status (rd_sel_status)
    );

    // assemble the live status word from state and flags
    always_comb begin
        status_w            = '0;
        status_w[READY_BIT] = (eng_state == ENG_IDLE) || (eng_state == ENG_SUSP);
        status_w[SUSP_BIT]  = (eng_state == ENG_SUSP);
        status_w[PEND_BIT]  = (eng_state == ENG_PEND);
        for (int i = 0; i < ERR_N; i++) status_w[ERR_POS[i]] = err_flags[i];
    end

    fsu_snapshot #(.W(STAT_W), .RST_VAL(STAT_RST)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .burst     (burst_rd),
        .status_in (status_w),
        .data      (rd_data)
    );
endmodule

// File: rtl/fsu_status_checker.sv
// Module: assertion checker for flash_status_unit, attached by bind.
module fsu_status_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_rd_array,
    input logic       cmd_clr_status,
    input logic       cmd_suspend,
    input logic       cmd_resume,
    input logic       eng_paused,
    input logic       eng_done,
    input logic       ce_n,
    input logic       oe_n,
    input logic       burst_rd,
    input logic [7:0] status,
    input logic [7:0] rd_data,
    input logic       rd_sel_status
);
    localparam logic [7:0] ERR_MASK = 8'h3A;

    p_clr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr_status |=> (status & ERR_MASK) == 8'h00);

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_clr_status |=> ((status & ERR_MASK) & $past(status & ERR_MASK))
                            == $past(status & ERR_MASK));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$fell(ce_n) && !$fell(oe_n)) |=> $stable(rd_data));

    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(ce_n) || $fell(oe_n)) && !burst_rd) |=> rd_data == $past(status));

    p_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        burst_rd |=> $stable(rd_data));

    p_idle_susp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !status[6] && cmd_suspend) |=> (!status[6] && !status[0]));

    p_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !eng_paused && !eng_done) |=> (status[0] && !status[7]));

    p_resume_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && cmd_resume) |=> (!status[6] && !status[7]));

    p_busy_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[7] && cmd_rd_array && rd_sel_status) |=> rd_sel_status);

    p_bit2_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] == 1'b0);
endmodule

bind flash_status_unit fsu_status_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_rd_array   (cmd_rd_array),
    .cmd_clr_status (cmd_clr_status),
    .cmd_suspend    (cmd_suspend),
    .cmd_resume     (cmd_resume),
    .eng_paused     (eng_paused),
    .eng_done       (eng_done),
    .ce_n           (ce_n),
    .oe_n           (oe_n),
    .burst_rd       (burst_rd),
    .status         (status_w),
    .rd_data        (rd_data),
    .rd_sel_status  (rd_sel_status)
);

// File: tb/tb_flash_status_unit.sv
module tb_flash_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_rd_status = 0, cmd_rd_array = 0, cmd_clr_status = 0;
    logic       cmd_suspend = 0, cmd_resume = 0;
    logic       eng_start = 0, eng_paused = 0, eng_done = 0;
    logic [3:0] eng_err = '0;
    logic       ce_n = 1'b1, oe_n = 1'b1, burst_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_sel_status;

    int n_checks = 0;
    int n_errs   = 0;

    always #5 clk = ~clk;

    flash_status_unit dut (.*);

    // bench cycle model: 0 idle, 1 busy, 2 pending, 3 suspended
    int         m_st = 0;
    logic [3:0] m_err = '0;
    logic       m_sel = 1'b0;
    logic [7:0] m_snap = 8'h80;
    logic       m_ce = 1'b1, m_oe = 1'b1;
    bit         m_ok = 0;

    function automatic logic [7:0] stat_of(int st, logic [3:0] e);
        logic [7:0] s = '0;
        s[7] = (st == 0) || (st == 3);
        s[6] = (st == 3);
        s[0] = (st == 2);
        s[1] = e[0]; s[3] = e[1]; s[4] = e[2]; s[5] = e[3];
        return s;
    endfunction

    function automatic int next_st(int st);
        case (st)
            0: return eng_start ? 1 : 0;
            1: return eng_done ? 0 : (cmd_suspend ? 2 : 1);
            2: return eng_done ? 0 : (eng_paused ? 3 : 2);
            default: return cmd_resume ? 1 : 3;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [7:0] s;
        s = stat_of(m_st, m_err);
        if (!rst_n) begin
            m_st = 0; m_err = '0; m_sel = 0; m_snap = 8'h80;
        end else begin
            if (((m_ce && !ce_n) || (m_oe && !oe_n)) && !burst_rd) m_snap = s;
            if (eng_start && m_st == 0)                        m_sel = 1;
            else if (cmd_rd_status)                            m_sel = 1;
            else if (cmd_rd_array && (m_st == 0 || m_st == 3)) m_sel = 0;
            m_err = cmd_clr_status ? 4'h0 : (m_err | eng_err);
            m_st  = next_st(m_st);
        end
        m_ce = ce_n; m_oe = oe_n;
        m_ok = 1;
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    // continuous comparison against the model, one field per requirement
    always @(negedge clk) if (m_ok) begin
        chk("R2 ready bit",   {7'd0, rd_data[7]}, {7'd0, m_snap[7]});
        chk("R3 suspend bit", {7'd0, rd_data[6]}, {7'd0, m_snap[6]});
        chk("R4 pending/b2",  rd_data & 8'h05, m_snap & 8'h05);
        chk("R5 error flags", rd_data & 8'h3A, m_snap & 8'h3A);
        chk("R8 read copy",   rd_data, m_snap);
        chk("R7 read select", {7'd0, rd_sel_status}, {7'd0, m_sel});
    end

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: eng_start = 1;   1: eng_paused = 1;  2: eng_done = 1;
            3: cmd_suspend = 1; 4: cmd_resume = 1;  5: cmd_rd_array = 1;
            6: cmd_clr_status = 1; default: cmd_rd_status = 1;
        endcase
        @(negedge clk);
        {eng_start, eng_paused, eng_done, cmd_suspend, cmd_resume,
         cmd_rd_array, cmd_clr_status, cmd_rd_status} = '0;
    endtask

    task automatic err_pulse(input logic [3:0] e, input logic clr);
        @(negedge clk); eng_err = e; cmd_clr_status = clr;
        @(negedge clk); eng_err = '0; cmd_clr_status = 0;
    endtask

    task automatic read_status(input logic [7:0] exp, input string tag);
        @(negedge clk); ce_n = 1; oe_n = 1;
        @(negedge clk); ce_n = 0;
        @(negedge clk); chk(tag, rd_data, exp);
        ce_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset word", rd_data, 8'h80);
        chk("R1 reset select", {7'd0, rd_sel_status}, 8'h00);
        read_status(8'h80, "R1 reset read");

        pulse(3);                                   // suspend while idle
        read_status(8'h80, "R10 idle suspend ignored");

        pulse(0);                                   // start
        read_status(8'h00, "R2 busy reads 0x00");
        chk("R7 start forces status", {7'd0, rd_sel_status}, 8'h01);
        pulse(5);                                   // read array while busy
        chk("R7 array ignored when busy", {7'd0, rd_sel_status}, 8'h01);
        pulse(0);                                   // start while busy
        read_status(8'h00, "R11 start ignored when busy");
        pulse(3);
        read_status(8'h01, "R4 suspend pending");
        pulse(1);
        read_status(8'hC0, "R3 suspended");
        pulse(5);
        chk("R7 array while suspended", {7'd0, rd_sel_status}, 8'h00);
        pulse(4);
        read_status(8'h00, "R3 resume clears bit6");
        pulse(3);
        pulse(2);                                   // done before paused
        read_status(8'h80, "R3 done beats pause");
        pulse(1);                                   // late paused, ignored
        read_status(8'h80, "R11 paused ignored when idle");

        err_pulse(4'b0100, 1'b1);
        read_status(8'h80, "R6 clear wins");
        err_pulse(4'b0100, 1'b0);
        read_status(8'h90, "R5 bit4 set");
        err_pulse(4'b0001, 1'b0);
        repeat (5) @(negedge clk);
        read_status(8'h92, "R5 flags sticky");
        pulse(6);
        read_status(8'h80, "R5 clear command");

        @(negedge clk); burst_rd = 1;
        err_pulse(4'b1000, 1'b0);
        @(negedge clk); ce_n = 0;
        @(negedge clk); chk("R9 burst keeps copy", rd_data, 8'h80);
        ce_n = 1; burst_rd = 0;
        read_status(8'hA0, "R8 single read copies");
        @(negedge clk); ce_n = 0;
        err_pulse(4'b0010, 1'b0);
        @(negedge clk); chk("R8 frozen while low", rd_data, 8'hA0);
        oe_n = 0;
        @(negedge clk); chk("R8 oe fall copies", rd_data, 8'hA8);
        ce_n = 1; oe_n = 1;
        pulse(6);

        // constrained random phase, checked by the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            eng_start      = ($urandom_range(0, 99) < 6);
            eng_paused     = ($urandom_range(0, 99) < 10);
            eng_done       = ($urandom_range(0, 99) < 5);
            cmd_suspend    = ($urandom_range(0, 99) < 6);
            cmd_resume     = ($urandom_range(0, 99) < 6);
            cmd_rd_array   = ($urandom_range(0, 99) < 8);
            cmd_rd_status  = ($urandom_range(0, 99) < 4);
            cmd_clr_status = ($urandom_range(0, 99) < 4);
            eng_err        = ($urandom_range(0, 99) < 8) ? 4'($urandom_range(1, 15)) : 4'h0;
            if ($urandom_range(0, 99) < 30) ce_n = ~ce_n;
            if ($urandom_range(0, 99) < 30) oe_n = ~oe_n;
            burst_rd       = ($urandom_range(0, 99) < 20);
            if ($urandom_range(0, 999) < 3) rst_n = 0; else rst_n = 1;
        end
        @(negedge clk);
        rst_n = 1;
        {eng_start, eng_paused, eng_done, cmd_suspend, cmd_resume,
         cmd_rd_array, cmd_clr_status, cmd_rd_status} = '0;
        eng_err = '0;
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end
endmodule